// File: doc/BRIEF.md
# Dual-Tone Spread-FSK Tone Synthesizer

This block turns a serial bit stream into a sampled sine wave for a power-line transmitter. A 0 bit is sent as a tone at the programmed space frequency and a 1 bit as a tone at the programmed mark frequency. Both carriers are held in registers in units of 10 Hz. A phase accumulator counts modulo the clock rate divided by 10 Hz, so every carrier is generated exactly. Moving from one tone to the other changes only the phase step, so the waveform never jumps. The block also outputs the current bit as a plain logic level, and a transmitter enable that is held on for a fixed time after the last bit.

Bits arrive on a valid/ready interface that is paced by a bit-boundary strobe, `bit_tick`, which is one clock wide. A bit moves only in a cycle where `in_valid`, `bit_tick` and `in_ready` are all high. `in_ready` is high only when `bit_tick` is high and the carrier pair is legal. The source must hold `in_valid` and `in_data` steady until the bit has moved. A strobe that moves no bit while a frame is running ends the frame. The next accepted bit then starts a new frame at phase zero. The nominal clock is 12 MHz. All frequency figures below assume that clock.

Top module: `sfsk_tone_synth`

## Requirements
- R1: While a frame runs, the phase step is the space register when the current bit is 0 and the mark register when it is 1.
- R2: A write of `cfg_freq` (`cfg_sel` 0 = space, 1 = mark) is stored only if it lies in 900..9500 (9 kHz..95 kHz in 10 Hz units). Otherwise the register keeps its value, and `cfg_reject` is high for the one cycle after that write. After any other cycle it is low.
- R3: `cfg_err` is high whenever the absolute difference of the two registers is 1000 or less.
- R4: The phase counts modulo 1,200,000 and advances by the step on every clock of a frame. With index i = floor(phase*1024/1200000), the sample is round(2047*sin(2*pi*(i+0.5)/1024)), with halves rounded away from zero. The sample appears on `sample` one cycle after the phase holds that value.
- R5: At a bit boundary inside a frame, the phase keeps its accumulated value. Only the step changes.
- R6: The clock edge that accepts the first bit of a frame sets the phase to zero, so the first sample of the frame is the index-0 value, +6.
- R7: `tx_bit` shows the bit whose tone is in the same cycle's `sample`. It is 0 outside a frame.
- R8: `sample` is zero from the cycle after a frame ends, and at all times outside frames.
- R9: `tx_en` goes high on the edge that accepts the first bit. It stays high through the frame and for exactly 4500 cycles after the edge where the frame ends, unless a new frame starts first.
- R10: `in_ready` equals `bit_tick` while `cfg_err` is low, and is low while `cfg_err` is high. No bit is accepted without `in_valid`.
- R11: After reset, space = 6340, mark = 7460, and `sample`, `tx_bit`, `tx_en`, `cfg_reject` and `cfg_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 12 MHz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Carrier register write strobe |
| cfg_sel | input | 1 | Register select: 0 space, 1 mark |
| cfg_freq | input | 14 | Carrier value in 10 Hz units |
| cfg_reject | output | 1 | Pulse: last write was out of range |
| cfg_err | output | 1 | Carrier pair too close together |
| bit_tick | input | 1 | Bit boundary strobe |
| in_valid | input | 1 | Source has a bit ready |
| in_ready | output | 1 | Bit is taken in this cycle |
| in_data | input | 1 | Bit value |
| sample | output | 12 | Signed sine sample |
| tx_bit | output | 1 | Value of the bit being sent |
| tx_en | output | 1 | Transmitter enable |

## Verification
A phase register that wraps at the wrong point or takes the wrong step gives a wrong `sample` within a few cycles. A phase that is not zeroed at frame start shows in the very first sample of the frame. A phase that is wrongly cleared at a bit boundary shows in the sample right after that boundary. A bit register or release counter that is out of step shows on `tx_bit` or `tx_en` at the first boundary, or at the end of the 4500-cycle window. A wrong stored carrier shows in `cfg_reject`, in `cfg_err`, or in the tone of the next bit that uses it.

// File: rtl/sfsk_pkg.sv
package sfsk_pkg;

  typedef enum logic {TONE_SPACE = 1'b0, TONE_MARK = 1'b1} tone_e;

  // Quarter-wave entry k of a table with qn entries and peak amp,
  // sampled at the centre of each step, computed by Taylor series.
  function automatic int quarter_sine(input int k, input int qn, input int amp);
    real ang;
    real term;
    real acc;
    ang  = 3.14159265358979323846 * (2.0 * k + 1.0) / (4.0 * qn);
    term = ang;
    acc  = ang;
    for (int n = 1; n < 12; n++) begin
      term = -term * ang * ang / ((2.0 * n) * (2.0 * n + 1.0));
      acc  = acc + term;
    end
    return $rtoi(amp * acc + 0.5);
  endfunction

endpackage

// File: rtl/sfsk_cfg_regs.sv
module sfsk_cfg_regs #(
  parameter int FW        = 14,
  parameter int FMIN      = 900,
  parameter int FMAX      = 9500,
  parameter int MIN_SEP   = 1000,
  parameter int SPACE_RST = 6340,
  parameter int MARK_RST  = 7460
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [FW-1:0] val,
  output logic [FW-1:0] space_f,
  output logic [FW-1:0] mark_f,
  output logic          reject,
  output logic          pair_err
);
  logic [FW-1:0] freq_q [2];
  logic          in_range;
  logic [FW-1:0] diff;

  assign in_range = (val >= FW'(FMIN)) && (val <= FW'(FMAX));

  for (genvar t = 0; t < 2; t++) begin : g_tone
    localparam logic [FW-1:0] RST_V = (t == 0) ? FW'(SPACE_RST) : FW'(MARK_RST);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        freq_q[t] <= RST_V;
      else if (we && in_range && (sel == 1'(t)))
        freq_q[t] <= val;
    end

    a_r2_stays_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_q[t] >= FW'(FMIN)) && (freq_q[t] <= FW'(FMAX)));
    a_r2_bad_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !in_range) |=> $stable(freq_q[t]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject <= 1'b0;
    else        reject <= we && !in_range;
  end

  assign space_f  = freq_q[0];
  assign mark_f   = freq_q[1];
  assign diff     = (freq_q[0] > freq_q[1]) ? (freq_q[0] - freq_q[1]) : (freq_q[1] - freq_q[0]);
  assign pair_err = diff <= FW'(MIN_SEP);

endmodule

// File: rtl/sfsk_phase_acc.sv
module sfsk_phase_acc #(
  parameter int MOD   = 1200000,
  parameter int PH_W  = 21,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PH_W-1:0]  inc,
  output logic [PH_W-1:0]  phase,
  output logic [IDX_W-1:0] idx
);
  // Exact floor(phase * 2^IDX_W / MOD) through a reciprocal multiply.
  localparam int          NUM_W = PH_W + IDX_W;
  localparam int          SH    = NUM_W + $clog2(MOD);
  localparam logic [63:0] RECIP = ((64'd1 << SH) + 64'(MOD) - 64'd1) / 64'(MOD);

  logic [PH_W:0]  sum;
  logic [PH_W:0]  wrapped;
  logic [63:0]    num;
  logic [63:0]    prod;

  assign sum     = {1'b0, phase} + {1'b0, inc};
  assign wrapped = (sum >= (PH_W+1)'(MOD)) ? (sum - (PH_W+1)'(MOD)) : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else if (run) phase <= wrapped[PH_W-1:0];
  end

  assign num  = {{(64-NUM_W){1'b0}}, phase, {IDX_W{1'b0}}};
  assign prod = num * RECIP;
  assign idx  = prod[SH +: IDX_W];

  a_r4_phase_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(MOD));
  a_r6_frame_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0) && (idx == '0));
  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(phase));

endmodule

// File: rtl/sfsk_sine_lut.sv
module sfsk_sine_lut #(
  parameter int IDX_W = 10,
  parameter int SW    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [IDX_W-1:0]     idx,
  output logic signed [SW-1:0] sample
);
  import sfsk_pkg::*;

  localparam int QB  = IDX_W - 2;
  localparam int QN  = 1 << QB;
  localparam int AMP = (1 << (SW - 1)) - 1;

  logic signed [SW-1:0] rom [QN];
  logic [QB-1:0]        addr;
  logic signed [SW-1:0] mag;
  logic signed [SW-1:0] value;

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam int VAL = quarter_sine(k, QN, AMP);
    assign rom[k] = SW'(VAL);
  end

  // Quadrant 1 and 3 read the table backwards; 2 and 3 negate.
  assign addr  = idx[IDX_W-2] ? ~idx[QB-1:0] : idx[QB-1:0];
  assign mag   = rom[addr];
  assign value = idx[IDX_W-1] ? -mag : mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sample <= '0;
    else if (en) sample <= value;
    else         sample <= '0;
  end

  a_r4_upper_half_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !idx[IDX_W-1]) |=> (sample > 0));
  a_r4_lower_half_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx[IDX_W-1]) |=> (sample < 0));

endmodule

// File: rtl/sfsk_tx_ctrl.sv
module sfsk_tx_ctrl #(
  parameter int REL_CLKS = 4500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic in_valid,
  input  logic in_data,
  input  logic cfg_err,
  output logic in_ready,
  output logic sending,
  output logic cur_bit,
  output logic frame_start,
  output logic tx_bit,
  output logic tx_en
);
  import sfsk_pkg::*;

  localparam int REL_W = $clog2(REL_CLKS + 1);

  logic             accept;
  logic [REL_W-1:0] rel_cnt;
  tone_e            tone_q;

  assign in_ready    = bit_tick && !cfg_err;
  assign accept      = in_ready && in_valid;
  assign frame_start = accept && !sending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      tone_q  <= TONE_SPACE;
      rel_cnt <= '0;
    end else if (accept) begin
      sending <= 1'b1;
      tone_q  <= tone_e'(in_data);
      rel_cnt <= '0;
    end else if (bit_tick && sending) begin
      sending <= 1'b0;
      rel_cnt <= REL_W'(REL_CLKS);
    end else if (rel_cnt != '0) begin
      rel_cnt <= rel_cnt - 1'b1;
    end
  end

  assign cur_bit = (tone_q == TONE_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_bit <= 1'b0;
    else        tx_bit <= sending && cur_bit;
  end

  assign tx_en = sending || (rel_cnt != '0);

  a_r10_blocked_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !sending) |=> !sending);
  a_r9_enable_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sending) |-> tx_en);
  a_r9_enable_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> tx_en);
  a_r7_bit_echo: assert property (@(posedge clk) disable iff (!rst_n)
    sending |=> (tx_bit == $past(cur_bit)));

endmodule

// File: rtl/sfsk_tone_synth.sv
module sfsk_tone_synth #(
  parameter int CLK_HZ    = 12000000,
  parameter int STEP_HZ   = 10,
  parameter int FW        = 14,
  parameter int FMIN      = 900,
  parameter int FMAX      = 9500,
  parameter int MIN_SEP   = 1000,
  parameter int SPACE_RST = 6340,
  parameter int MARK_RST  = 7460,
  parameter int IDX_W     = 10,
  parameter int SW        = 12,
  parameter int REL_CLKS  = 4500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [FW-1:0]        cfg_freq,
  output logic                 cfg_reject,
  output logic                 cfg_err,
  input  logic                 bit_tick,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_data,
  output logic signed [SW-1:0] sample,
  output logic                 tx_bit,
  output logic                 tx_en
);
  localparam int MOD  = CLK_HZ / STEP_HZ;
  localparam int PH_W = $clog2(MOD);

  logic [FW-1:0]    space_f;
  logic [FW-1:0]    mark_f;
  logic             sending;
  logic             cur_bit;
  logic             frame_start;
  logic [PH_W-1:0]  inc;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] idx;

  sfsk_cfg_regs #(
    .FW(FW), .FMIN(FMIN), .FMAX(FMAX), .MIN_SEP(MIN_SEP),
    .SPACE_RST(SPACE_RST), .MARK_RST(MARK_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .val(cfg_freq),
    .space_f(space_f), .mark_f(mark_f), .reject(cfg_reject), .pair_err(cfg_err)
  );

  sfsk_tx_ctrl #(.REL_CLKS(REL_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_data(in_data), .cfg_err(cfg_err), .in_ready(in_ready),
    .sending(sending), .cur_bit(cur_bit), .frame_start(frame_start),
    .tx_bit(tx_bit), .tx_en(tx_en)
  );

  assign inc = cur_bit ? PH_W'(mark_f) : PH_W'(space_f);

  sfsk_phase_acc #(.MOD(MOD), .PH_W(PH_W), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .run(sending),
    .inc(inc), .phase(phase), .idx(idx)
  );

  sfsk_sine_lut #(.IDX_W(IDX_W), .SW(SW)) u_lut (
    .clk(clk), .rst_n(rst_n), .en(sending), .idx(idx), .sample(sample)
  );

endmodule

// File: tb/sfsk_tone_synth_tb.sv
module sfsk_tone_synth_tb;
  localparam int MODV = 1200000;
  localparam int RELV = 4500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [13:0] cfg_freq = '0;
  logic cfg_reject, cfg_err, in_ready, tx_bit, tx_en;
  logic bit_tick = 1'b0, in_valid = 1'b0, in_data = 1'b0;
  logic signed [11:0] sample;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sfsk_tone_synth u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_freq(cfg_freq), .cfg_reject(cfg_reject), .cfg_err(cfg_err),
    .bit_tick(bit_tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sample(sample), .tx_bit(tx_bit), .tx_en(tx_en)
  );

  // ---------------- reference model ----------------
  int m_space, m_mark, m_phase, m_rel, m_sample;
  bit m_send, m_bit, m_txbit, m_rej;

  function automatic int exp_sine(input int ph);
    longint i;
    real v;
    i = (longint'(ph) * 1024) / MODV;
    v = 2047.0 * $sin(2.0 * 3.14159265358979323846 * (real'(i) + 0.5) / 1024.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic bit too_close(input int a, input int b);
    return ((a > b) ? a - b : b - a) <= 1000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_space = 6340; m_mark = 7460; m_phase = 0; m_rel = 0;
      m_send = 0; m_bit = 0; m_sample = 0; m_txbit = 0; m_rej = 0;
    end else begin
      bit acc;
      int step;
      acc      = bit_tick && in_valid && !too_close(m_space, m_mark);
      m_sample = m_send ? exp_sine(m_phase) : 0;
      m_txbit  = m_send && m_bit;
      step     = m_bit ? m_mark : m_space;
      if (acc && !m_send)  m_phase = 0;
      else if (m_send)     m_phase = (m_phase + step) % MODV;
      if (acc) begin
        m_send = 1; m_bit = in_data; m_rel = 0;
      end else if (bit_tick && m_send) begin
        m_send = 0; m_rel = RELV;
      end else if (m_rel > 0) begin
        m_rel = m_rel - 1;
      end
      m_rej = cfg_we && (cfg_freq < 900 || cfg_freq > 9500);
      if (cfg_we && !m_rej) begin
        if (cfg_sel) m_mark = cfg_freq; else m_space = cfg_freq;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!m_send && m_sample == 0) check("R8 idle sample", sample, 0);
      else check("R1/R4/R5/R6 tone sample", sample, m_sample);
      check("R7 tx_bit", tx_bit, m_txbit);
      check("R9 tx_en", tx_en, (m_send || m_rel > 0) ? 1 : 0);
      check("R3 cfg_err", cfg_err, too_close(m_space, m_mark));
      check("R2 cfg_reject", cfg_reject, m_rej);
      check("R10 in_ready", in_ready, bit_tick && !too_close(m_space, m_mark));
    end
  end

  // ---------------- stimulus ----------------
  int tick_min = 30, tick_span = 40;

  initial begin
    int cnt;
    cnt = 20;
    forever begin
      @(posedge clk); #1;
      if (cnt == 0) begin
        bit_tick = 1'b1;
        cnt = tick_min + int'($urandom % tick_span);
      end else begin
        bit_tick = 1'b0;
        cnt--;
      end
    end
  end

  task automatic write_cfg(input bit sel, input int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_freq = 14'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send_bit(input bit b, input int limit);
    in_valid = 1'b1; in_data = b;
    for (int w = 0; w < limit; w++) begin
      @(negedge clk);
      if (bit_tick && in_ready) begin
        @(posedge clk); #1;
        return;
      end
    end
  endtask

  task automatic send_frame(input int nbits);
    for (int k = 0; k < nbits; k++) send_bit(1'($urandom), 200);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 reset sample", sample, 0);
    check("R11 reset tx_en", tx_en, 0);
    check("R11 reset tx_bit", tx_bit, 0);
    check("R11 reset cfg_err", cfg_err, 0);
    check("R11 reset cfg_reject", cfg_reject, 0);

    // Directed: first frame with default carriers, then full release.
    send_frame(12);
    idle(4700);

    // R2 boundaries and rejects
    write_cfg(0, 899);
    write_cfg(1, 9501);
    write_cfg(0, 0);
    write_cfg(1, 16383);
    write_cfg(0, 900);
    write_cfg(1, 9500);
    send_frame(6);
    idle(300);

    // R3: pair exactly 1000 apart blocks, 1001 apart allows
    write_cfg(0, 5000);
    write_cfg(1, 6000);
    send_bit(1'b1, 150);
    in_valid = 1'b0;
    write_cfg(1, 6001);
    send_frame(5);
    // new frame while release is counting
    idle(1000);
    send_frame(4);
    idle(4600);

    // Random frames and carrier changes
    for (int f = 0; f < 10; f++) begin
      if ($urandom % 3 == 0) write_cfg(1'($urandom), 800 + int'($urandom % 8900));
      if ($urandom % 4 == 0) begin
        write_cfg(0, 900 + int'($urandom % 8601));
        write_cfg(1, 900 + int'($urandom % 8601));
      end
      send_frame(3 + int'($urandom % 10));
      idle((f % 3 == 0) ? 4600 : int'($urandom % 3000));
    end
    idle(4600);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule